// File: doc/BRIEF.md
# Facility Data Link Byte Buffer

This block moves the bit-serial facility data link (FDL) channel of a framed line to and from bytes, in both directions. On the receive side each FDL bit arrives with a one-cycle strobe. The bits are gathered into an 8-bit byte. When the eighth bit arrives, the byte is copied to a holding register for the host. That copied byte is then compared against two programmable match bytes. A separate run detector watches the same received bits for eight consecutive ones, which marks an abort. On the transmit side the host loads a byte, and the block sends it one bit per transmit strobe. When the last bit has gone out, the block reports the buffer as empty and sends ones (idle) until the host loads again.

All events are collected in a 5-bit status vector. Each status bit stays set until the host clears it. The vector also records a transmit multiframe boundary, which the surrounding framer reports as a pulse. HDLC framing and bit stuffing belong to other logic.

Top module: `fdl_buf_ctrl`

## Requirements
- R1: After reset, `stat` is all zeros, `rx_byte` is 8'h00 and `tx_bit` is 1.
- R2: The receive side takes `rx_bit` only in cycles where `rx_strobe` is high, and ignores it otherwise. The first bit of each group of eight goes to bit 0 of the byte. On the eighth strobe, the assembled byte appears on `rx_byte` after the clock edge and `stat[0]` (receive full) becomes set. `rx_byte` holds its value between completed bytes.
- R3: `stat[2]` (match) becomes set in the same cycle as `stat[0]` when the completed byte equals `match_a` or `match_b`. A byte that is not yet complete never sets it.
- R4: `stat[3]` (abort) becomes set on the eighth consecutive strobed 1 received. A strobed 0 restarts the count, so seven ones followed by a 0 do not set it.
- R5: Once an abort has been reported, further ones do not report it again. A new abort needs a strobed 0 followed by eight more ones.
- R6: After a load, `tx_bit` presents bit 0 of the loaded byte. Each `tx_strobe` moves on to the next bit, up to bit 7.
- R7: The strobe that consumes bit 7 sets `stat[1]` (transmit empty). From then on `tx_bit` is 1 until the next load, and strobes change nothing.
- R8: `tx_load` replaces any transfer still in progress. It wins over a `tx_strobe` in the same cycle, and the new byte restarts from its bit 0.
- R9: A pulse on `tx_mframe` sets `stat[4]`.
- R10: Every status bit stays set until its bit in `stat_clr` is high. When a set event and a clear fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_strobe | input | 1 | Marks a valid received FDL bit |
| rx_bit | input | 1 | Received FDL bit |
| match_a | input | 8 | First match byte |
| match_b | input | 8 | Second match byte |
| rx_byte | output | 8 | Last completed received byte |
| tx_strobe | input | 1 | Requests the next transmit bit |
| tx_load | input | 1 | Loads `tx_data` into the transmit buffer |
| tx_data | input | 8 | Byte to transmit |
| tx_bit | output | 1 | Transmit FDL bit, 1 when idle |
| tx_mframe | input | 1 | Transmit multiframe boundary pulse |
| stat_clr | input | 5 | Per-bit clear of the status vector |
| stat | output | 5 | Sticky status: 0 rx full, 1 tx empty, 2 match, 3 abort, 4 tx multiframe |

## Verification
The assertions check several rules on every cycle:
- a match is reported only together with a full byte;
- the held byte changes only on a strobe;
- an abort never fires twice in a row;
- the transmit output idles high after the buffer empties without a reload;
- the status bits stay sticky, and a set wins over a clear.

Other behaviour shows only through the bench's scenarios, which compare against an independent model:
- the bit order of assembly and serialisation;
- the exact strobe on which a full, empty or abort event falls;
- abort re-arming only after a zero;
- a mid-transfer reload.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
  localparam int STAT_W     = 5;
  localparam int ST_RX_FULL = 0;
  localparam int ST_TX_EMPT = 1;
  localparam int ST_MATCH   = 2;
  localparam int ST_ABORT   = 3;
  localparam int ST_TX_MF   = 4;

  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/fdl_rx_asm.sv
module fdl_rx_asm #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic         bit_in,
  input  logic [W-1:0] pat_a,
  input  logic [W-1:0] pat_b,
  output logic [W-1:0] held,
  output logic         full_evt,
  output logic         match_evt
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic [W-1:0]  assembled;

  function automatic logic hits(input logic [W-1:0] b,
                                input logic [W-1:0] p0,
                                input logic [W-1:0] p1);
    return (b == p0) || (b == p1);
  endfunction

  assign assembled = {bit_in, shreg[W-1:1]};
  assign full_evt  = strobe && (cnt == CW'(W-1));
  assign match_evt = full_evt && hits(assembled, pat_a, pat_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      held  <= '0;
    end else if (strobe) begin
      shreg <= assembled;
      if (full_evt) begin
        cnt  <= '0;
        held <= assembled;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R3
  match_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |-> full_evt);

  // R2
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(held));
endmodule

// File: rtl/fdl_abort_det.sv
module fdl_abort_det #(
  parameter int RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic bit_in,
  output logic abort_evt
);
  localparam int OW = $clog2(RUN + 1);

  logic [OW-1:0] ones;

  assign abort_evt = strobe && bit_in && (ones == OW'(RUN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones <= '0;
    end else if (strobe) begin
      if (!bit_in)
        ones <= '0;
      else if (ones != OW'(RUN))
        ones <= ones + OW'(1);
    end
  end

  // R5
  abort_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !abort_evt);
endmodule

// File: rtl/fdl_tx_ser.sv
module fdl_tx_ser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  input  logic         strobe,
  output logic         bit_out,
  output logic         empty_evt
);
  localparam int RW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic [RW-1:0] rem;
  logic          busy;

  assign busy      = (rem != '0);
  assign bit_out   = busy ? shreg[0] : 1'b1;
  assign empty_evt = !load && strobe && (rem == RW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      rem   <= '0;
    end else if (load) begin
      shreg <= load_byte;
      rem   <= RW'(W);
    end else if (strobe && busy) begin
      shreg <= {1'b1, shreg[W-1:1]};
      rem   <= rem - RW'(1);
    end
  end

  // R7
  idle_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_evt && !load) |=> bit_out);
endmodule

// File: rtl/fdl_status.sv
module fdl_status #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] stat
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        stat[i] <= 1'b0;
      else if (set[i])
        stat[i] <= 1'b1;
      else if (clr[i])
        stat[i] <= 1'b0;
    end

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[i] && !clr[i]) |=> stat[i]);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set[i] && clr[i]) |=> stat[i]);
  end
endmodule

// File: rtl/fdl_buf_ctrl.sv
module fdl_buf_ctrl
  import fdl_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int ABORT_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_strobe,
  input  logic              rx_bit,
  input  logic [BYTE_W-1:0] match_a,
  input  logic [BYTE_W-1:0] match_b,
  output logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_strobe,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_bit,
  input  logic              tx_mframe,
  input  logic [STAT_W-1:0] stat_clr,
  output logic [STAT_W-1:0] stat
);
  logic  rx_full_evt;
  logic  rx_match_evt;
  logic  rx_abort_evt;
  logic  tx_empty_evt;
  stat_t set_vec;

  fdl_rx_asm #(.W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .strobe(rx_strobe), .bit_in(rx_bit),
    .pat_a(match_a), .pat_b(match_b), .held(rx_byte),
    .full_evt(rx_full_evt), .match_evt(rx_match_evt)
  );

  fdl_abort_det #(.RUN(ABORT_N)) u_abort (
    .clk(clk), .rst_n(rst_n), .strobe(rx_strobe), .bit_in(rx_bit),
    .abort_evt(rx_abort_evt)
  );

  fdl_tx_ser #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_byte(tx_data),
    .strobe(tx_strobe), .bit_out(tx_bit), .empty_evt(tx_empty_evt)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[ST_RX_FULL] = rx_full_evt;
    set_vec[ST_TX_EMPT] = tx_empty_evt;
    set_vec[ST_MATCH]   = rx_match_evt;
    set_vec[ST_ABORT]   = rx_abort_evt;
    set_vec[ST_TX_MF]   = tx_mframe;
  end

  fdl_status #(.N(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(stat_clr), .stat(stat)
  );

  // R2
  full_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_evt |=> stat[ST_RX_FULL]);

  // R9
  mframe_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mframe |=> stat[ST_TX_MF]);
endmodule

// File: tb/tb_fdl_buf_ctrl.sv
`timescale 1ns/1ps
module tb_fdl_buf_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       rx_strobe = 0, rx_bit = 0;
  logic [7:0] match_a = 8'h7E, match_b = 8'h81;
  logic [7:0] rx_byte;
  logic       tx_strobe = 0, tx_load = 0;
  logic [7:0] tx_data = 0;
  logic       tx_bit;
  logic       tx_mframe = 0;
  logic [4:0] stat_clr = 0;
  logic [4:0] stat;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fdl_buf_ctrl dut (
    .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_bit(rx_bit),
    .match_a(match_a), .match_b(match_b), .rx_byte(rx_byte),
    .tx_strobe(tx_strobe), .tx_load(tx_load), .tx_data(tx_data),
    .tx_bit(tx_bit), .tx_mframe(tx_mframe), .stat_clr(stat_clr), .stat(stat)
  );

  // independent reference model
  logic [7:0] m_bits, m_rx_byte, m_tx_data;
  int         m_n, m_ones, m_rem;
  logic [4:0] m_stat;

  function automatic logic exp_tx(int rem, logic [7:0] d);
    if (rem == 0) return 1'b1;
    return d[8 - rem];
  endfunction

  function automatic logic is_match(logic [7:0] b, logic [7:0] a, logic [7:0] c);
    return (b == a) || (b == c);
  endfunction

  always @(posedge clk) begin
    logic [4:0] s;
    if (!rst_n) begin
      m_bits = 0; m_rx_byte = 0; m_tx_data = 0;
      m_n = 0; m_ones = 0; m_rem = 0; m_stat = 0;
    end else begin
      s = 0;
      if (rx_strobe) begin
        m_bits[m_n] = rx_bit;
        m_n++;
        if (m_n == 8) begin
          m_rx_byte = m_bits; m_n = 0; s[0] = 1;
          if (is_match(m_bits, match_a, match_b)) s[2] = 1;
        end
        if (!rx_bit) m_ones = 0;
        else if (m_ones < 8) begin
          m_ones++;
          if (m_ones == 8) s[3] = 1;
        end
      end
      if (tx_load) begin
        m_tx_data = tx_data; m_rem = 8;
      end else if (tx_strobe && m_rem > 0) begin
        m_rem--;
        if (m_rem == 0) s[1] = 1;
      end
      if (tx_mframe) s[4] = 1;
      m_stat = s | (m_stat & ~stat_clr);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(stat[0] == m_stat[0], "R2", "rx full flag", stat[0], m_stat[0]);
      check(stat[1] == m_stat[1], "R7", "tx empty flag", stat[1], m_stat[1]);
      check(stat[2] == m_stat[2], "R3", "match flag", stat[2], m_stat[2]);
      check(stat[3] == m_stat[3], "R4", "abort flag", stat[3], m_stat[3]);
      check(stat[4] == m_stat[4], "R9", "mframe flag", stat[4], m_stat[4]);
      check(rx_byte == m_rx_byte, "R2", "rx byte", rx_byte, m_rx_byte);
      check(tx_bit == exp_tx(m_rem, m_tx_data), "R6", "tx bit", tx_bit,
            exp_tx(m_rem, m_tx_data));
    end
  end

  task automatic step(input logic rs, input logic rb, input logic ts,
                      input logic ld, input logic [7:0] d,
                      input logic mf, input logic [4:0] clr);
    rx_strobe = rs; rx_bit = rb; tx_strobe = ts; tx_load = ld;
    tx_data = d; tx_mframe = mf; stat_clr = clr;
    @(posedge clk);
    @(negedge clk);
    rx_strobe = 0; tx_strobe = 0; tx_load = 0; tx_mframe = 0; stat_clr = 0;
  endtask

  task automatic rx_send(input logic b);
    step(1, b, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pat;
    void'($urandom(32'h5EED_F0D1));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(stat == 5'b0, "R1", "stat after reset", stat, 0);
    check(rx_byte == 8'h00, "R1", "rx_byte after reset", rx_byte, 0);
    check(tx_bit == 1'b1, "R1", "tx idle after reset", tx_bit, 1);

    // R2 / R3: byte 7E matches match_a, strobe-less bits in between ignored
    pat = 8'h7E;
    for (int i = 0; i < 8; i++) begin
      rx_send(pat[i]);
      if (i == 3) step(0, 1, 0, 0, 0, 0, 0);
    end
    check(rx_byte == 8'h7E, "R2", "assembled byte", rx_byte, 8'h7E);
    check(stat[0] == 1, "R2", "full flag set", stat[0], 1);
    check(stat[2] == 1, "R3", "match on pattern a", stat[2], 1);
    check(stat[3] == 0, "R4", "six ones, no abort", stat[3], 0);
    step(0, 0, 0, 0, 0, 0, 5'b11111);
    pat = 8'h81;
    for (int i = 0; i < 8; i++) rx_send(pat[i]);
    check(stat[2] == 1, "R3", "match on pattern b", stat[2], 1);
    step(0, 0, 0, 0, 0, 0, 5'b11111);
    pat = 8'h12;
    for (int i = 0; i < 7; i++) rx_send(pat[i]);
    check(stat[0] == 0, "R2", "no full after 7 bits", stat[0], 0);
    rx_send(pat[7]);
    check(stat[2] == 0, "R3", "no match on 12", stat[2], 0);
    check(rx_byte == 8'h12, "R2", "second byte", rx_byte, 8'h12);

    // R4: seven ones then zero, then eight ones
    step(0, 0, 0, 0, 0, 0, 5'b11111);
    repeat (7) rx_send(1);
    rx_send(0);
    check(stat[3] == 0, "R4", "7 ones then 0", stat[3], 0);
    repeat (7) rx_send(1);
    check(stat[3] == 0, "R4", "7 ones", stat[3], 0);
    rx_send(1);
    check(stat[3] == 1, "R4", "8th one", stat[3], 1);
    // R5 saturation
    step(0, 0, 0, 0, 0, 0, 5'b01000);
    repeat (10) rx_send(1);
    check(stat[3] == 0, "R5", "no re-report without 0", stat[3], 0);
    rx_send(0);
    repeat (8) rx_send(1);
    check(stat[3] == 1, "R5", "re-armed after 0", stat[3], 1);

    // R6 / R7 transmit
    step(0, 0, 0, 0, 0, 0, 5'b11111);
    step(0, 0, 0, 1, 8'h3C, 0, 0);
    for (int i = 0; i < 8; i++) begin
      check(tx_bit == pat_bit(8'h3C, i), "R6", "tx serial bit", tx_bit, pat_bit(8'h3C, i));
      step(0, 0, 1, 0, 0, 0, 0);
    end
    check(stat[1] == 1, "R7", "empty after 8 bits", stat[1], 1);
    check(tx_bit == 1, "R7", "idle ones", tx_bit, 1);
    step(0, 0, 1, 0, 0, 0, 5'b00010);
    check(stat[1] == 0 && tx_bit == 1, "R7", "strobe when idle", {stat[1], tx_bit}, 1);

    // R8 reload mid-transfer, load wins over strobe
    step(0, 0, 0, 1, 8'hAA, 0, 0);
    repeat (3) step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 1, 8'hF0, 0, 0);
    check(tx_bit == 0, "R8", "reload starts at bit 0", tx_bit, 0);
    check(stat[1] == 0, "R8", "no empty on reload", stat[1], 0);
    repeat (4) step(0, 0, 1, 0, 0, 0, 0);
    check(tx_bit == 1, "R8", "bit 4 of F0", tx_bit, 1);

    // R9 / R10
    step(0, 0, 0, 0, 0, 1, 5'b10000);
    check(stat[4] == 1, "R10", "set wins over clear", stat[4], 1);
    step(0, 0, 0, 0, 0, 0, 0);
    check(stat[4] == 1, "R10", "sticky", stat[4], 1);
    step(0, 0, 0, 0, 0, 0, 5'b10000);
    check(stat[4] == 0, "R10", "cleared", stat[4], 0);

    // constrained random phase, checked by the model every cycle
    for (int k = 0; k < 4000; k++) begin
      logic [4:0] c;
      if (k % 500 == 0) begin
        match_a = 8'($urandom_range(0, 255));
        match_b = 8'($urandom_range(0, 3) == 0 ? 8'hFF : $urandom_range(0, 255));
      end
      c = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'b0;
      step($urandom_range(0, 2) != 0, $urandom_range(0, 3) != 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 19) == 0,
           8'($urandom), $urandom_range(0, 30) == 0, c);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  function automatic logic pat_bit(logic [7:0] b, int i);
    return b[i];
  endfunction
endmodule